// File: doc/BRIEF.md
# Two-Class Weighted Round-Robin Grant Arbiter

This block decides which of `NUM_CH` channels may use a shared data mover. Each channel supplies a request line, a class bit and a weight. Channels in the high class always come before channels in the low class. Inside a class, service rotates by channel index. A granted channel keeps the mover for a number of consecutive service slots set by its weight. The mover sends a one-cycle `slot_done` pulse at the end of every slot, and the arbiter makes its decisions only at those boundaries, or at any cycle when nothing is granted.

The control is a three-state machine. In `ST_IDLE` nothing is granted. In `ST_SERVE_LO` a low-class channel holds the grant, and in `ST_SERVE_HI` a high-class channel holds it. The named transitions are:
- IDLE_TO_HI: leave idle for a high-class request.
- IDLE_TO_LO: leave idle when only low-class channels request.
- LO_STAY and HI_STAY: keep the class, either by continuing the same channel or by rotating to the next one.
- LO_TO_HI: preemption at a slot boundary.
- HI_TO_LO: the high class runs dry.
- SERVE_TO_IDLE: nothing is requesting at a slot boundary.

Each class keeps its own rotation pointer and its own remaining-credit count. A low-class run that is cut short by preemption can therefore pick up where it stopped.

Top module: `wrr2_arbiter`

## Requirements
- R1: After reset, `grant` is all zeros and `grant_valid` is 0. Both class pointers sit at channel `NUM_CH-1`, so the first pick in either class searches upward from channel 0.
- R2: `grant` is one-hot or zero, with bit i meaning channel i. `grant_valid` is 1 exactly when `grant` is non-zero. While a grant is held and `slot_done` is low, `grant` does not change.
- R3: When nothing is granted and at least one request is high at a clock edge, a grant to a requesting channel is visible after that edge.
- R4: When a new grant is chosen and any channel with `ch_high[i]=1` is requesting, the grant goes to such a channel.
- R5: A low-class grant is preempted only at a `slot_done` pulse, and only when a high-class request is present at that pulse.
- R6: A channel whose 4-bit weight field `ch_weight[4*i +: 4]` holds W keeps the grant for W consecutive `slot_done` pulses. The decision at the W-th pulse then rotates.
- R7: A weight of 0 behaves as a weight of 1.
- R8: Rotation inside a class picks the first requesting channel of that class at indices after the class's last newly granted channel, wrapping at `NUM_CH-1`. The last channel itself is considered last.
- R9: A low-class channel that is preempted with credit left, and is still requesting in the low class when the low class is next chosen, is granted again for exactly its remaining slots.
- R10: If the granted channel's request is low at a `slot_done` pulse, the grant leaves it at that pulse whatever credit remains, and that credit is discarded.
- R11: Weight changes take effect only when a channel's credit is reloaded at a fresh grant. Class changes of the held channel take effect only at its next decision.
- R12: A `slot_done` pulse while nothing is granted has no effect. With no requests, the block stays idle.
- R13: If no channel requests at a `slot_done` pulse, the grant is dropped and `grant_valid` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_req | input | NUM_CH | Request line per channel |
| ch_high | input | NUM_CH | Class bit per channel: 1 = high class, 0 = low class |
| ch_weight | input | NUM_CH*WEIGHT_W | Weight per channel, channel i at bits [WEIGHT_W*i +: WEIGHT_W] |
| slot_done | input | 1 | One-cycle pulse from the data mover at the end of each slot |
| grant | output | NUM_CH | One-hot grant, bit i = channel i |
| grant_valid | output | 1 | High while any channel holds the grant |

## Verification
The assertions check the cycle-local properties on every cycle:
- the one-hot shape of `grant` and its agreement with `grant_valid`;
- grant stability between slot boundaries;
- that an idle arbiter starts a grant for a requester, and prefers the high class when it does;
- that a dropped request forces the grant to move at the next pulse;
- that the block stays idle when nothing requests.

The properties that depend on history need the bench's scenarios and its reference model. These are:
- the exact number of slots a weight buys, including weight zero;
- the rotation order after the last owner;
- resuming a preempted low-class run with its leftover credit;
- ignoring a weight change in the middle of a run.

// File: rtl/wrr2_pkg.sv
package wrr2_pkg;

    // Arbiter control states; the encoding is internal only.
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_SERVE_LO = 2'd1,
        ST_SERVE_HI = 2'd2
    } arb_state_e;

    // Class indices used for per-class context arrays.
    localparam logic CLS_LO = 1'b0;
    localparam logic CLS_HI = 1'b1;

endpackage

// File: rtl/wrr2_rr_pick.sv
// Rotating first-one finder: returns the first set bit of cand strictly
// after position last, wrapping around; position last itself comes last.
module wrr2_rr_pick #(
    parameter int unsigned NUM_CH = 6,
    parameter int unsigned IW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] cand,
    input  logic [IW-1:0]     last,
    output logic              hit,
    output logic [IW-1:0]     pick
);

    always_comb begin
        hit  = 1'b0;
        pick = '0;
        for (int k = 1; k <= int'(NUM_CH); k++) begin
            int p;
            p = int'(last) + k;
            if (p >= int'(NUM_CH)) begin
                p = p - int'(NUM_CH);
            end
            if (!hit && cand[p]) begin
                hit  = 1'b1;
                pick = IW'(p);
            end
        end
    end

endmodule

// File: rtl/wrr2_class_ctx.sv
// Per-class context: last newly granted channel and remaining credit.
module wrr2_class_ctx #(
    parameter int unsigned NUM_CH   = 6,
    parameter int unsigned WEIGHT_W = 4,
    parameter int unsigned IW       = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ld_owner,
    input  logic [IW-1:0]       owner_d,
    input  logic                ld_credit,
    input  logic [WEIGHT_W-1:0] credit_d,
    output logic [IW-1:0]       owner_q,
    output logic [WEIGHT_W-1:0] credit_q
);

    localparam logic [IW-1:0] OWNER_RST = IW'(NUM_CH - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner_q <= OWNER_RST;
        end else if (ld_owner) begin
            owner_q <= owner_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            credit_q <= '0;
        end else if (ld_credit) begin
            credit_q <= credit_d;
        end
    end

endmodule

// File: rtl/wrr2_arbiter.sv
module wrr2_arbiter #(
    parameter int unsigned NUM_CH   = 6,
    parameter int unsigned WEIGHT_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_CH-1:0]            ch_req,
    input  logic [NUM_CH-1:0]            ch_high,
    input  logic [NUM_CH*WEIGHT_W-1:0]   ch_weight,
    input  logic                         slot_done,
    output logic [NUM_CH-1:0]            grant,
    output logic                         grant_valid
);

    import wrr2_pkg::*;

    localparam int unsigned IW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [WEIGHT_W-1:0] ONE_CREDIT = WEIGHT_W'(1);

    // ---------------- state and context ----------------
    arb_state_e st_q, st_d;
    logic [IW-1:0] cur_q, cur_d;

    logic [1:0][NUM_CH-1:0]   cls_mask;
    logic [1:0]               cls_any;
    logic [1:0]               pick_hit;
    logic [1:0][IW-1:0]       pick_idx;
    logic [1:0][IW-1:0]       own_q;
    logic [1:0][IW-1:0]       own_d;
    logic [1:0]               ld_own;
    logic [1:0][WEIGHT_W-1:0] cred_q;
    logic [1:0][WEIGHT_W-1:0] cred_d;
    logic [1:0]               ld_cred;
    logic [NUM_CH-1:0][WEIGHT_W-1:0] wt_a;

    assign wt_a = ch_weight;

    // Live class membership of the requests.
    assign cls_mask[CLS_LO] = ch_req & ~ch_high;
    assign cls_mask[CLS_HI] = ch_req &  ch_high;

    generate
        for (genvar c = 0; c < 2; c++) begin : g_cls
            assign cls_any[c] = |cls_mask[c];

            wrr2_rr_pick #(
                .NUM_CH (NUM_CH),
                .IW     (IW)
            ) u_pick (
                .cand (cls_mask[c]),
                .last (own_q[c]),
                .hit  (pick_hit[c]),
                .pick (pick_idx[c])
            );

            wrr2_class_ctx #(
                .NUM_CH   (NUM_CH),
                .WEIGHT_W (WEIGHT_W),
                .IW       (IW)
            ) u_ctx (
                .clk       (clk),
                .rst_n     (rst_n),
                .ld_owner  (ld_own[c]),
                .owner_d   (own_d[c]),
                .ld_credit (ld_cred[c]),
                .credit_d  (cred_d[c]),
                .owner_q   (own_q[c]),
                .credit_q  (cred_q[c])
            );
        end
    endgenerate

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cur_q <= '0;
        end else begin
            st_q  <= st_d;
            cur_q <= cur_d;
        end
    end

    // ---------------- decision logic ----------------
    logic                serving;
    logic                cur_cls;
    logic                preempt;
    logic                cur_req;
    logic                decide;
    logic                keep;
    logic [WEIGHT_W-1:0] rem;
    logic                tgt;
    logic                tgt_any;
    logic [WEIGHT_W-1:0] held_cred;
    logic [WEIGHT_W-1:0] reload;

    always_comb begin
        unique case (st_q)
            ST_IDLE: begin
                serving = 1'b0;
                cur_cls = CLS_LO;
                preempt = 1'b0;
            end
            ST_SERVE_LO: begin
                serving = 1'b1;
                cur_cls = CLS_LO;
                preempt = cls_any[CLS_HI];
            end
            ST_SERVE_HI: begin
                serving = 1'b1;
                cur_cls = CLS_HI;
                preempt = 1'b0;
            end
            default: begin
                serving = 1'b0;
                cur_cls = CLS_LO;
                preempt = 1'b0;
            end
        endcase
    end

    assign cur_req = ch_req[cur_q];
    assign rem     = cred_q[cur_cls] - ONE_CREDIT;
    assign decide  = !serving || slot_done;
    assign keep    = serving && slot_done && cur_req && (rem != '0) && !preempt;
    assign tgt_any = cls_any[CLS_HI] || cls_any[CLS_LO];
    assign tgt     = cls_any[CLS_HI] ? CLS_HI : CLS_LO;

    // Credit of the target class that may be resumed; the class that just
    // finished a run never resumes it.
    assign held_cred = (serving && (tgt == cur_cls)) ? '0 : cred_q[tgt];

    // Weight zero counts as one slot.
    assign reload = (wt_a[pick_idx[tgt]] == '0) ? ONE_CREDIT : wt_a[pick_idx[tgt]];

    always_comb begin
        st_d    = st_q;
        cur_d   = cur_q;
        ld_own  = '0;
        own_d   = own_q;
        ld_cred = '0;
        cred_d  = cred_q;
        if (decide) begin
            if (keep) begin
                // LO_STAY / HI_STAY on the same channel
                ld_cred[cur_cls] = 1'b1;
                cred_d[cur_cls]  = rem;
            end else begin
                if (serving) begin
                    // Park leftover credit only for a preempted, still-requesting owner.
                    ld_cred[cur_cls] = 1'b1;
                    cred_d[cur_cls]  = (preempt && cur_req) ? rem : '0;
                end
                if (!tgt_any) begin
                    st_d = ST_IDLE;                       // SERVE_TO_IDLE
                end else begin
                    if ((held_cred != '0) && cls_mask[tgt][own_q[tgt]]) begin
                        cur_d = own_q[tgt];               // resume parked run
                    end else begin
                        cur_d        = pick_idx[tgt];
                        ld_own[tgt]  = 1'b1;
                        own_d[tgt]   = pick_idx[tgt];
                        ld_cred[tgt] = 1'b1;
                        cred_d[tgt]  = reload;
                    end
                    // IDLE_TO_HI, LO_TO_HI, HI_STAY / IDLE_TO_LO, HI_TO_LO, LO_STAY
                    st_d = tgt ? ST_SERVE_HI : ST_SERVE_LO;
                end
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        grant       = '0;
        grant_valid = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                grant       = '0;
                grant_valid = 1'b0;
            end
            ST_SERVE_LO, ST_SERVE_HI: begin
                grant[cur_q] = 1'b1;
                grant_valid  = 1'b1;
            end
            default: begin
                grant       = '0;
                grant_valid = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/wrr2_arbiter_chk.sv
module wrr2_arbiter_chk #(
    parameter int unsigned NUM_CH = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_CH-1:0] ch_req,
    input logic [NUM_CH-1:0] ch_high,
    input logic              slot_done,
    input logic [NUM_CH-1:0] grant,
    input logic              grant_valid
);

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)) else $error("grant not one-hot"); // R2

    AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid == (grant != '0)) else $error("valid mismatch"); // R2

    AST_HOLD_BETWEEN_SLOTS: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && !slot_done) |=> ($stable(grant) && grant_valid)) else $error("grant moved mid-slot"); // R2

    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && (ch_req != '0)) |=> ((grant & $past(ch_req)) != '0)) else $error("idle did not grant"); // R3

    AST_HIGH_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && ((ch_req & ch_high) != '0)) |=> ((grant & $past(ch_req & ch_high)) != '0)) else $error("low won over high"); // R4

    AST_DROP_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && slot_done && ((grant & ch_req) == '0)) |=> (grant != $past(grant))) else $error("dropped owner kept grant"); // R10

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!grant_valid && (ch_req == '0)) |=> !grant_valid) else $error("spurious grant"); // R12

    AST_EMPTY_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid && slot_done && (ch_req == '0)) |=> !grant_valid) else $error("grant kept with no requests"); // R13

endmodule

bind wrr2_arbiter wrr2_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ch_req      (ch_req),
    .ch_high     (ch_high),
    .slot_done   (slot_done),
    .grant       (grant),
    .grant_valid (grant_valid)
);

// File: tb/wrr2_arbiter_bench.sv
module wrr2_arbiter_bench;

    localparam int CLK_P = 10;
    localparam int N     = 6;
    localparam int WW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  high = '0;
    logic [N*WW-1:0] wt = '0;
    logic          slot = 1'b0;
    logic [N-1:0]  grant;
    logic          grant_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit fin = 1'b0;

    // reference model state: m_st 0 idle, 1 low class, 2 high class
    int m_st, m_cur;
    int m_own [2];
    int m_cred [2];

    always #(CLK_P/2) clk = ~clk;

    wrr2_arbiter #(.NUM_CH(N), .WEIGHT_W(WW)) u_wrr2_arbiter (
        .clk(clk), .rst_n(rst_n), .ch_req(req), .ch_high(high),
        .ch_weight(wt), .slot_done(slot), .grant(grant), .grant_valid(grant_valid)
    );

    function automatic int wt_of(input int ch);
        int w;
        w = int'(wt[ch*WW +: WW]);
        return (w == 0) ? 1 : w;
    endfunction

    task automatic set_w(input int ch, input int v);
        wt[ch*WW +: WW] = WW'(v);
    endtask

    task automatic model_reset();
        m_st = 0; m_cur = 0;
        for (int c = 0; c < 2; c++) begin
            m_own[c] = N - 1;
            m_cred[c] = 0;
        end
    endtask

    task automatic model_step();
        logic [N-1:0] hi, lo, msk;
        int cls, rem, t;
        bit serving, preempt;
        hi = req & high;
        lo = req & ~high;
        serving = (m_st != 0);
        cls = serving ? m_st - 1 : 0;
        preempt = (m_st == 1) && (hi != '0);
        if (!serving || slot) begin
            rem = serving ? m_cred[cls] - 1 : 0;
            if (serving && slot && req[m_cur] && rem > 0 && !preempt) begin
                m_cred[cls] = rem;
            end else begin
                if (serving) m_cred[cls] = (preempt && req[m_cur]) ? rem : 0;
                t = (hi != '0) ? 1 : ((lo != '0) ? 0 : -1);
                if (t < 0) begin
                    m_st = 0;
                end else begin
                    msk = (t == 1) ? hi : lo;
                    if (m_cred[t] > 0 && msk[m_own[t]]) begin
                        m_cur = m_own[t];
                    end else begin
                        for (int k = 1; k <= N; k++) begin
                            int p;
                            p = (m_own[t] + k) % N;
                            if (msk[p]) begin
                                m_cur = p; m_own[t] = p; m_cred[t] = wt_of(p);
                                break;
                            end
                        end
                    end
                    m_st = t + 1;
                end
            end
        end
    endtask

    task automatic check_model(input string rq);
        logic [N-1:0] eg;
        eg = (m_st != 0) ? (N'(1) << m_cur) : '0;
        n_chk++;
        if (grant !== eg || grant_valid !== (m_st != 0)) begin
            n_bad++;
            $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%0d",
                     rq, grant, grant_valid, eg, (m_st != 0));
        end
    endtask

    task automatic check_lit(input string rq, input logic [N-1:0] eg);
        n_chk++;
        if (grant !== eg || grant_valid !== (eg != '0)) begin
            n_bad++;
            $display("FAIL %s: grant=%b valid=%b expected grant=%b valid=%0d",
                     rq, grant, grant_valid, eg, (eg != '0));
        end
    endtask

    task automatic step(input string rq);
        @(posedge clk);
        model_step();
        #1;
        check_model(rq);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = '0; slot = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        model_reset();
        check_lit("R1", '0);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!fin) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < N; i++) set_w(i, 1);

        // R1, R3, R7, R6: weight 0 and weight 2 in the low class
        do_reset();
        set_w(0, 0); set_w(1, 2);
        req = 6'b000011;
        step("R3"); check_lit("R3", 6'b000001);
        slot = 1'b1;
        step("R7"); check_lit("R7", 6'b000010);
        step("R6"); check_lit("R6", 6'b000010);
        step("R6"); check_lit("R6", 6'b000001);
        slot = 1'b0;

        // R5, R9, R8: preempt low run, resume with leftover credit
        do_reset();
        set_w(2, 5); set_w(3, 1); set_w(4, 1);
        req = 6'b001100;
        step("R8"); check_lit("R8", 6'b000100);
        slot = 1'b1;
        step("R6"); step("R6");
        slot = 1'b0; high[4] = 1'b1; req[4] = 1'b1;
        step("R5"); check_lit("R5", 6'b000100);
        slot = 1'b1;
        step("R5"); check_lit("R5", 6'b010000);
        req[4] = 1'b0;
        step("R9"); check_lit("R9", 6'b000100);
        step("R9"); check_lit("R9", 6'b000100);
        step("R8"); check_lit("R8", 6'b001000);
        slot = 1'b0; high = '0;

        // R10: owner drops request with credit left
        do_reset();
        set_w(1, 4); set_w(5, 1);
        req = 6'b100010;
        step("R10"); check_lit("R10", 6'b000010);
        req[1] = 1'b0;
        step("R2"); check_lit("R2", 6'b000010);
        slot = 1'b1;
        step("R10"); check_lit("R10", 6'b100000);
        slot = 1'b0;

        // R11: weight change mid-run ignored
        do_reset();
        set_w(0, 2); set_w(1, 1);
        req = 6'b000011;
        step("R11"); check_lit("R11", 6'b000001);
        set_w(0, 7);
        slot = 1'b1;
        step("R11"); check_lit("R11", 6'b000001);
        step("R11"); check_lit("R11", 6'b000010);
        slot = 1'b0;

        // R4: simultaneous low and high from idle
        do_reset();
        high = 6'b100000; req = 6'b100001;
        step("R4"); check_lit("R4", 6'b100000);
        high = '0;

        // R12, R13: idle slot pulses, release on empty
        do_reset();
        slot = 1'b1;
        step("R12"); check_lit("R12", '0);
        req = 6'b001000;
        step("R3"); check_lit("R3", 6'b001000);
        req = '0;
        step("R13"); check_lit("R13", '0);
        slot = 1'b0;

        // random traffic against the reference model
        do_reset();
        for (int cyc = 0; cyc < 4000; cyc++) begin
            if (cyc % 60 == 0) begin
                high = N'($urandom);
                for (int i = 0; i < N; i++) set_w(i, int'($urandom % 16));
            end
            req  = N'($urandom) & N'($urandom);
            slot = ($urandom % 3) != 0;
            step("R2");
        end

        fin = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule